// File: doc/BRIEF.md
# SSI Master Position Reader

This block is the controller end of a synchronous serial link to an absolute position sensor. When `start` is seen while the block is idle, it drives a burst of clock pulses on `sclk`. The first falling edge tells the sensor to freeze its reading. After each rising edge the sensor puts one bit on the data line. The block samples each bit a fixed number of system cycles after the rising edge it drove. That delay allows for the cable and the driver, and also for the two-flop synchronizer on `sdata`.

When the burst is complete, the block splits the received word into an error flag and a position field. It converts the field from Gray code when Gray mode was selected, and sign-extends the field to the output width. It then shows the result for one cycle, with `valid` high. After the last pulse the block checks that the sensor holds the line low, as its recovery timer requires. It then waits out two full clock periods of recovery before it accepts another read. This limits the read rate to one read per (frame bits + 3) clock periods.

`HALF_DIV` sets the length of each half period of `sclk`, counted in system cycles. `SAMPLE_DLY` sets how many cycles after a rising edge the bit is sampled. The frame format and the Gray selection are inputs, and the block captures them when a read starts.

Top module: `ssi_reader`

## Requirements
- R1: After reset, and whenever no read is in progress, `sclk` is high. After reset, `valid`, `pos`, `sens_err` and `link_err` are all zero.
- R2: The `fmt` code selects the frame length n: 0 gives 24 bits, 1 gives 25, 2 gives 26 and 3 gives 32. Each read drives exactly n+1 falling edges on `sclk`.
- R3: Each low phase of `sclk` lasts exactly `HALF_DIV` system cycles.
- R4: Frame bits are received most significant bit first. The first bit is the error flag, then the null bits (3 in 32-bit mode, 1 in the other modes), then the position field. The position field is 22, 23, 24 or 28 bits wide for `fmt` codes 0 to 3. Each bit is sampled `SAMPLE_DLY` cycles after the rising edge that presents it. In binary mode (`gray`=0), `pos` is the field read as two's complement and sign-extended. `pos` changes only when `valid` is high.
- R5: With `gray`=1, the field is converted from reflected Gray code to binary, and the result is then sign-extended.
- R6: `sens_err` shows the received error bit (1 means the sensor reports an error). It changes only when `valid` is high.
- R7: After the final rising edge, the line is sampled once more. If it is high rather than low, `link_err` is 1 with the result; otherwise it is 0.
- R8: A `start` during a burst or during recovery is ignored. Two successive first falling edges are at least (n+3)·2·`HALF_DIV` cycles apart.
- R9: Each read produces exactly one `valid` pulse, one cycle wide.
- R10: `fmt` and `gray` are captured when a read starts. Changing them later in the read has no effect on that read's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Read request, taken only when idle |
| fmt | input | 2 | Frame format code |
| gray | input | 1 | 1: position field is Gray coded |
| sdata | input | 1 | Serial data from the sensor |
| sclk | output | 1 | Serial clock to the sensor, idles high |
| valid | output | 1 | One-cycle result strobe |
| pos | output | POS_W | Signed, sign-extended position |
| sens_err | output | 1 | Error bit received from the sensor |
| link_err | output | 1 | Line was not low after the last pulse |

## Verification
The bench builds the block with `HALF_DIV`=8 and `SAMPLE_DLY`=5. These values give a 16-cycle serial period, so a 32-bit read with its recovery fits in about 600 cycles. Many reads in every format, in both codings and with fault injection, therefore fit in a short run. The sensor model answers two cycles after each rising edge. With the synchronizer, this puts a data change close to the sampling point, so a wrong sampling offset or a wrong bit order corrupts the result. A start held high across reads makes the recovery spacing measurable at the pins.

// File: rtl/ssi_reader.sv
module ssi_reader #(
  parameter int HALF_DIV   = 36,
  parameter int SAMPLE_DLY = 10,
  parameter int POS_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              fmt,
  input  logic                    gray,
  input  logic                    sdata,
  output logic                    sclk,
  output logic                    valid,
  output logic signed [POS_W-1:0] pos,
  output logic                    sens_err,
  output logic                    link_err
);

  localparam int FRAME_MAX = 32;
  localparam int REC_LEN   = 4 * HALF_DIV;
  localparam int CW        = $clog2(REC_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_REC} st_t;

  st_t                  state;
  logic [CW-1:0]        cnt;
  logic [5:0]           idx;
  logic [1:0]           fmt_q;
  logic                 gray_q;
  logic [FRAME_MAX-1:0] sh;
  logic [1:0]           sync;
  logic                 mono_bad;

  logic [5:0]           n_bits;
  logic [4:0]           w_bits;
  logic [POS_W-1:0]     mask, field, bin, ext;
  logic                 din;

  assign din = sync[1];

  always_comb begin
    case (fmt_q)
      2'd0:    begin n_bits = 6'd24; w_bits = 5'd22; end
      2'd1:    begin n_bits = 6'd25; w_bits = 5'd23; end
      2'd2:    begin n_bits = 6'd26; w_bits = 5'd24; end
      default: begin n_bits = 6'd32; w_bits = 5'd28; end
    endcase
  end

  assign mask  = (POS_W'(1) << w_bits) - POS_W'(1);
  assign field = POS_W'(sh) & mask;

  always_comb begin
    for (int i = 0; i < POS_W; i++)
      bin[i] = gray_q ? ^(field >> i) : field[i];
  end

  assign ext = bin[w_bits - 5'd1] ? (bin | ~mask) : bin;

  wire last_half = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      fmt_q    <= '0;
      gray_q   <= 1'b0;
      sh       <= '0;
      sync     <= 2'b11;
      mono_bad <= 1'b0;
      sclk     <= 1'b1;
      valid    <= 1'b0;
      pos      <= '0;
      sens_err <= 1'b0;
      link_err <= 1'b0;
    end else begin
      sync  <= {sync[0], sdata};
      valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_LOW;
            cnt      <= '0;
            idx      <= '0;
            fmt_q    <= fmt;
            gray_q   <= gray;
            mono_bad <= 1'b0;
            sclk     <= 1'b0;
          end
        end
        S_LOW: begin
          if (last_half) begin
            state <= S_HIGH;
            cnt   <= '0;
            sclk  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt == CW'(SAMPLE_DLY)) begin
            if (idx < n_bits) sh <= {sh[FRAME_MAX-2:0], din};
            else              mono_bad <= din;
          end
          if (last_half) begin
            cnt <= '0;
            if (idx == n_bits) begin
              state    <= S_REC;
              valid    <= 1'b1;
              pos      <= ext;
              sens_err <= sh[n_bits[4:0] - 5'd1];
              link_err <= mono_bad;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LOW;
              sclk  <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(REC_LEN - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ssi_reader_chk.sv
module ssi_reader_chk #(
  parameter int HALF_DIV = 36,
  parameter int POS_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             valid,
  input logic [POS_W-1:0] pos,
  input logic             sens_err,
  input logic             link_err,
  input logic [1:0]       st,
  input logic [1:0]       fq
);

  logic [15:0] lowrun;
  logic [6:0]  nfall;
  logic        sclk_d;
  logic [6:0]  exp_falls;

  always_comb begin
    case (fq)
      2'd0:    exp_falls = 7'd25;
      2'd1:    exp_falls = 7'd26;
      2'd2:    exp_falls = 7'd27;
      default: exp_falls = 7'd33;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun <= '0;
      nfall  <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_d <= sclk;
      lowrun <= sclk ? '0 : lowrun + 16'd1;
      if (valid)                nfall <= '0;
      else if (sclk_d && !sclk) nfall <= nfall + 7'd1;
    end
  end

  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> sclk);

  // R2
  fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (nfall == exp_falls));

  // R3
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= 16'(HALF_DIV));

  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> valid);

  // R6
  sens_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sens_err) |-> valid);

  // R7
  link_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_err) |-> valid);

  // R8
  recovery_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |=> sclk);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

endmodule

bind ssi_reader ssi_reader_chk #(.HALF_DIV(HALF_DIV), .POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .valid    (valid),
  .pos      (pos),
  .sens_err (sens_err),
  .link_err (link_err),
  .st       (state),
  .fq       (fmt_q)
);

// File: tb/sim_ssi_reader.sv
module sim_ssi_reader;
  localparam int CLK_P = 10;
  localparam int H     = 8;
  localparam int SD    = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, gray = 1'b0, sdata = 1'b1;
  logic [1:0] fmt = 2'd0;
  logic sclk, valid, sens_err, link_err;
  logic signed [31:0] pos;

  always #(CLK_P/2) clk = ~clk;

  ssi_reader #(.HALF_DIV(H), .SAMPLE_DLY(SD), .POS_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .gray(gray),
    .sdata(sdata), .sclk(sclk), .valid(valid), .pos(pos),
    .sens_err(sens_err), .link_err(link_err));

  typedef struct {
    logic signed [31:0] p;
    logic e;
    logic l;
    int n;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // sensor model
  logic [31:0] tx_word = '0;
  int tx_n = 32;
  bit tx_fault = 1'b0;

  initial begin : sensor
    forever begin
      @(negedge sclk);
      begin
        int n;
        logic [31:0] w;
        bit f;
        n = tx_n; w = tx_word; f = tx_fault;
        for (int k = 0; k <= n; k++) begin
          @(posedge sclk);
          repeat (2) @(negedge clk);
          sdata = (k < n) ? w[n-1-k] : f;
        end
        repeat (4*H) @(negedge clk);
        sdata = 1'b1;
      end
    end
  end

  // monitor
  int falls = 0, lowrun = 0, nbursts = 0, sp_n = 0;
  logic ps = 1'b1, pv = 1'b0;
  longint cyc = 0, t_first = -1;
  bit chk_sp = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst_n) begin
      if (ps && !sclk) begin
        if (falls == 0) begin
          nbursts++;
          if (chk_sp && t_first >= 0)
            chk(cyc - t_first >= (sp_n+3)*2*H, "R8", "first-fall spacing",
                cyc - t_first, (sp_n+3)*2*H);
          t_first = cyc;
        end
        falls++;
      end
      if (!sclk) lowrun++;
      else begin
        if (!ps) chk(lowrun == H, "R3", "low phase cycles", lowrun, H);
        lowrun = 0;
      end
      if (pv) chk(!valid, "R9", "valid width", valid, 0);
      if (valid) begin
        if (q.size() == 0) chk(1'b0, "R9", "unexpected valid", 1, 0);
        else begin
          e = q.pop_front();
          chk(pos == e.p, e.tag, "position", pos, e.p);
          chk(sens_err == e.e, "R6", "sensor error bit", sens_err, e.e);
          chk(link_err == e.l, "R7", "monoflop check", link_err, e.l);
          chk(falls == e.n + 1, "R2", "falling edges", falls, e.n + 1);
        end
        falls = 0;
      end
      pv = valid;
    end
    ps = sclk;
  end

  function automatic int flen(input logic [1:0] f);
    return (f == 2'd0) ? 24 : (f == 2'd1) ? 25 : (f == 2'd2) ? 26 : 32;
  endfunction

  function automatic int fwid(input logic [1:0] f);
    return (f == 2'd0) ? 22 : (f == 2'd1) ? 23 : (f == 2'd2) ? 24 : 28;
  endfunction

  task automatic setup_frame(input logic [1:0] f, input bit g, input bit err,
                             input int p, input bit fault, input string tag);
    int n, w;
    logic [31:0] m, v, fld;
    exp_t e;
    n = flen(f); w = fwid(f);
    m = (32'h1 << w) - 32'h1;
    v = p & m;
    fld = g ? (v ^ (v >> 1)) : v;
    tx_word = (32'(err) << (n-1)) | fld;
    tx_n = n; tx_fault = fault;
    e.p = p; e.e = err; e.l = fault; e.n = n; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4*H + 4) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] f, input bit g, input bit err,
                         input int p, input bit fault, input bit scram,
                         input bit extra, input string tag);
    setup_frame(f, g, err, p, fault, tag);
    @(negedge clk); fmt = f; gray = g; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (scram) begin
      repeat (3) @(negedge clk);
      fmt = ~f; gray = ~g;
    end
    if (extra) begin
      repeat (flen(f) * H) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (2*H) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat ((flen(f) + 4) * 2 * H) @(negedge clk);
      // R8: no burst followed the ignored requests
      chk(falls == 0, "R8", "burst after ignored start", falls, 0);
    end
    drain();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(sclk == 1'b1, "R1", "idle sclk", sclk, 1);
    chk(valid == 1'b0, "R1", "reset valid", valid, 0);
    chk(pos == 0, "R1", "reset pos", pos, 0);
    chk(sens_err == 1'b0 && link_err == 1'b0, "R1", "reset flags",
        {sens_err, link_err}, 0);

    do_read(2'd3, 1'b0, 1'b0, 32'h0123_4567, 1'b0, 1'b0, 1'b0, "R4");
    do_read(2'd3, 1'b0, 1'b0, -5,            1'b0, 1'b0, 1'b0, "R4");
    do_read(2'd0, 1'b0, 1'b0, 2097151,       1'b0, 1'b0, 1'b0, "R4");
    do_read(2'd0, 1'b0, 1'b0, -2097152,      1'b0, 1'b0, 1'b0, "R4");
    do_read(2'd1, 1'b1, 1'b0, -1234,         1'b0, 1'b0, 1'b0, "R5");
    do_read(2'd2, 1'b1, 1'b0, 32'h003A_5A5A, 1'b0, 1'b0, 1'b0, "R5");
    do_read(2'd3, 1'b1, 1'b1, -100000,       1'b0, 1'b0, 1'b0, "R5");
    do_read(2'd2, 1'b0, 1'b1, 4660,          1'b1, 1'b0, 1'b0, "R4");
    do_read(2'd1, 1'b0, 1'b0, -77,           1'b0, 1'b1, 1'b0, "R10");
    do_read(2'd0, 1'b1, 1'b0, 31337,         1'b0, 1'b0, 1'b1, "R5");

    // R8: start held across two reads
    setup_frame(2'd0, 1'b0, 1'b0, 777, 1'b0, "R4");
    setup_frame(2'd0, 1'b0, 1'b0, 777, 1'b0, "R4");
    sp_n = 24; t_first = -1; chk_sp = 1'b1;
    @(negedge clk); fmt = 2'd0; gray = 1'b0; start = 1'b1;
    while (nbursts < 12) @(negedge clk);
    start = 1'b0;
    drain();
    chk_sp = 1'b0;

    repeat (10) @(negedge clk);
    // R9
    chk(q.size() == 0, "R9", "pending results", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule